// File: doc/BRIEF.md
# Register-Amount Shifter with Carry

This block shifts a data word by a count taken from a register operand and reports the carry that the shift produces. Four shift kinds are supported: logical left, logical right, arithmetic right and rotate right. Only the bottom byte of the amount operand sets the count. The upper bits of the operand are ignored. The carry rules are exact for counts of zero, counts equal to the word width, and counts above the word width.

The block is purely combinational. It sits in an execute stage beside the adder. The stage supplies the operand, the amount register, the 2-bit kind code and the current carry flag. In the same cycle it takes back the shifted word, the new carry and a flag that says whether the carry may have changed.

The pins carry no stream traffic. There is no valid/ready pair and no back-pressure: an output is valid whenever its inputs have settled. The word width is a parameter and must be a power of two. All numbers below assume the default width of 32 and a count field of 8 bits.

Top module: `regshift_top`

## Requirements
- R1: Only `shift_amt[7:0]` sets the count n. The bits `shift_amt[31:8]` have no effect on any output.
- R2: When n is 0, for every kind, `res_word` equals `data_in`, `res_carry` equals `carry_in` and `carry_upd` is 0.
- R3: Kind 2'b00 (logical left) with n from 1 to 31 gives `data_in << n`, and the carry is `data_in[32-n]`.
- R4: Kind 2'b00 with n of 32 or more gives a result of 0. The carry is `data_in[0]` when n is exactly 32 and 0 when n is above 32.
- R5: Kind 2'b01 (logical right) with n from 1 to 31 gives `data_in >> n` with the carry `data_in[n-1]`. With n of exactly 32 the result is 0 and the carry is `data_in[31]`. Above 32 both the result and the carry are 0.
- R6: Kind 2'b10 (arithmetic right) with n from 1 to 31 fills from the sign bit and sets the carry to `data_in[n-1]`. With n of 32 or more, every result bit and the carry equal `data_in[31]`.
- R7: Kind 2'b11 (rotate right) rotates by m = n mod 32. When m is non-zero the carry is `data_in[m-1]`.
- R8: Kind 2'b11 with n a non-zero multiple of 32 (32, 64, ... 224) leaves the word unchanged and sets the carry to `data_in[31]`.
- R9: `carry_upd` is 1 exactly when n is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | 32 | Word to be shifted |
| shift_amt | input | 32 | Amount register; only bits 7:0 are used |
| shift_kind | input | 2 | 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right |
| carry_in | input | 1 | Current carry flag |
| res_word | output | 32 | Shifted word |
| res_carry | output | 1 | Carry after the shift |
| carry_upd | output | 1 | High when the carry may have changed |

## Verification
Embedded assertions check several rules at every input change. They check the zero-count pass-through and the update flag. They check that a left or logical-right shift by 32 or more clears the word, and that an arithmetic shift by 32 or more fills the word with copies of the sign. They also check that a rotate carry matches the top bit of the rotated result. The exact bit picked for the carry at each count from 1 to 31, and the boundary between 32 and 33, can be shown only by the bench. So can the fact that the upper amount bits are ignored. The bench sweeps every kind against all 256 counts on several data patterns.

// File: rtl/regshift_pkg.sv
package regshift_pkg;
  typedef enum logic [1:0] {
    KIND_LSL = 2'b00,
    KIND_LSR = 2'b01,
    KIND_ASR = 2'b10,
    KIND_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/regshift_left.sv
// Left barrel shifter over W+1 bits; the extra top bit catches the last bit out.
module regshift_left #(
  parameter int W  = 32,
  parameter int CW = 8
) (
  input  logic [W-1:0]  din,
  input  logic [CW-1:0] cnt,
  output logic [W-1:0]  dout,
  output logic          cout
);
  logic [W:0] stg [0:CW];
  assign stg[0] = {1'b0, din};

  for (genvar k = 0; k < CW; k++) begin : g_stage
    localparam int SH = 1 << k;
    if (SH > W) begin : g_flush
      assign stg[k+1] = cnt[k] ? '0 : stg[k];
    end else begin : g_move
      assign stg[k+1] = cnt[k] ? (stg[k] << SH) : stg[k];
    end
  end

  assign dout = stg[CW][W-1:0];
  assign cout = stg[CW][W];
endmodule

// File: rtl/regshift_right.sv
// Right barrel shifter over W+1 bits with a selectable fill bit; the extra
// bottom bit catches the last bit shifted out.
module regshift_right #(
  parameter int W  = 32,
  parameter int CW = 8
) (
  input  logic [W-1:0]  din,
  input  logic [CW-1:0] cnt,
  input  logic          fill,
  output logic [W-1:0]  dout,
  output logic          cout
);
  logic [W:0] stg [0:CW];
  assign stg[0] = {din, 1'b0};

  for (genvar k = 0; k < CW; k++) begin : g_stage
    localparam int SH = 1 << k;
    if (SH > W) begin : g_flush
      assign stg[k+1] = cnt[k] ? {(W+1){fill}} : stg[k];
    end else begin : g_move
      assign stg[k+1] = cnt[k] ? {{SH{fill}}, stg[k][W:SH]} : stg[k];
    end
  end

  assign dout = stg[CW][W:1];
  assign cout = stg[CW][0];
endmodule

// File: rtl/regshift_rotate.sv
// Rotate-right barrel over log2(W) stages; W must be a power of two.
module regshift_rotate #(
  parameter int W  = 32,
  parameter int LG = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [LG-1:0] cnt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stg [0:LG];
  assign stg[0] = din;

  for (genvar k = 0; k < LG; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stg[k+1] = cnt[k] ? {stg[k][SH-1:0], stg[k][W-1:SH]} : stg[k];
  end

  assign dout = stg[LG];
endmodule

// File: rtl/regshift_top.sv
module regshift_top
  import regshift_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 32,
  parameter int CNT_W = 8
) (
  input  logic [W-1:0]     data_in,
  input  logic [AMT_W-1:0] shift_amt,
  input  logic [1:0]       shift_kind,
  input  logic             carry_in,
  output logic [W-1:0]     res_word,
  output logic             res_carry,
  output logic             carry_upd
);
  localparam int LG = $clog2(W);

  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;
  logic             unused_amt_hi;
  shift_kind_e      kind;

  assign cnt           = shift_amt[CNT_W-1:0];
  assign unused_amt_hi = ^shift_amt[AMT_W-1:CNT_W];
  assign cnt_zero      = (cnt == '0);
  assign kind          = shift_kind_e'(shift_kind);

  logic [W-1:0] lsl_word, rsh_word, ror_word;
  logic         lsl_c, rsh_c, rsh_fill;

  assign rsh_fill = (kind == KIND_ASR) ? data_in[W-1] : 1'b0;

  regshift_left #(.W(W), .CW(CNT_W)) u_left (
    .din(data_in), .cnt(cnt), .dout(lsl_word), .cout(lsl_c)
  );

  regshift_right #(.W(W), .CW(CNT_W)) u_right (
    .din(data_in), .cnt(cnt), .fill(rsh_fill), .dout(rsh_word), .cout(rsh_c)
  );

  regshift_rotate #(.W(W), .LG(LG)) u_rot (
    .din(data_in), .cnt(cnt[LG-1:0]), .dout(ror_word)
  );

  always_comb begin
    res_word  = data_in;
    res_carry = carry_in;
    if (!cnt_zero) begin
      unique case (kind)
        KIND_LSL: begin res_word = lsl_word; res_carry = lsl_c;       end
        KIND_LSR,
        KIND_ASR: begin res_word = rsh_word; res_carry = rsh_c;       end
        KIND_ROR: begin res_word = ror_word; res_carry = ror_word[W-1]; end
        default:  begin res_word = data_in;  res_carry = carry_in;    end
      endcase
    end
  end

  assign carry_upd = !cnt_zero;

  // Embedded checks on the settled combinational outputs.
  always_comb begin
    if (!$isunknown({data_in, shift_amt, shift_kind, carry_in})) begin
      if (shift_amt[CNT_W-1:0] == '0) begin
        assert_zero_pass_R2: assert (res_word == data_in && res_carry == carry_in && !carry_upd)
          else $error("zero count changed state");
      end else begin
        assert_upd_flag_R9: assert (carry_upd)
          else $error("carry_upd low on non-zero count");
      end
      if (shift_kind == 2'b00 && shift_amt[CNT_W-1:0] >= CNT_W'(W)) begin
        assert_left_clear_R4: assert (res_word == '0)
          else $error("left shift by width or more not zero");
      end
      if (shift_kind == 2'b01 && shift_amt[CNT_W-1:0] >= CNT_W'(W)) begin
        assert_right_clear_R5: assert (res_word == '0)
          else $error("logical right by width or more not zero");
      end
      if (shift_kind == 2'b10 && shift_amt[CNT_W-1:0] >= CNT_W'(W)) begin
        assert_sign_fill_R6: assert (res_word == {W{data_in[W-1]}} && res_carry == data_in[W-1])
          else $error("arithmetic right by width or more not sign filled");
      end
      if (shift_kind == 2'b11 && shift_amt[CNT_W-1:0] != '0) begin
        assert_rot_carry_R7: assert (res_carry == res_word[W-1])
          else $error("rotate carry not top result bit");
      end
    end
  end
endmodule

// File: tb/regshift_top_tb_top.sv
`timescale 1ns/1ps
module regshift_top_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] data_in, shift_amt, res_word;
  logic [1:0]  shift_kind;
  logic        carry_in, res_carry, carry_upd;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  regshift_top dut_i (
    .data_in(data_in), .shift_amt(shift_amt), .shift_kind(shift_kind),
    .carry_in(carry_in), .res_word(res_word), .res_carry(res_carry),
    .carry_upd(carry_upd)
  );

  function automatic string req_tag(input logic [1:0] k, input int n);
    if (n == 0) return "R2";
    case (k)
      2'b00: return (n < 32) ? "R3" : "R4";
      2'b01: return "R5";
      2'b10: return "R6";
      default: return (n % 32 == 0) ? "R8" : "R7";
    endcase
  endfunction

  task automatic run_one(input logic [31:0] v, input logic [1:0] k, input int n,
                         input logic [23:0] hi, input logic ci, input string tag);
    logic [31:0] ew;
    logic        ec;
    int          m;
    data_in    = v;
    shift_kind = k;
    shift_amt  = {hi, 8'(n)};
    carry_in   = ci;
    ew = v;
    ec = ci;
    if (n != 0) begin
      case (k)
        2'b00: begin
          ew = (n >= 32) ? 32'h0 : (v << n);
          ec = (n < 32) ? v[32-n] : ((n == 32) ? v[0] : 1'b0);
        end
        2'b01: begin
          ew = (n >= 32) ? 32'h0 : (v >> n);
          ec = (n < 32) ? v[n-1] : ((n == 32) ? v[31] : 1'b0);
        end
        2'b10: begin
          ew = (n >= 32) ? {32{v[31]}} : 32'($signed(v) >>> n);
          ec = (n < 32) ? v[n-1] : v[31];
        end
        default: begin
          m  = n % 32;
          ew = (m == 0) ? v : ((v >> m) | (v << (32 - m)));
          ec = (m == 0) ? v[31] : v[m-1];
        end
      endcase
    end
    @(negedge clk);
    checks++;
    if (res_word !== ew || res_carry !== ec) begin
      errors++;
      $display("FAIL %s kind=%0d n=%0d v=%h: word %h carry %0b, expected %h carry %0b",
               tag, k, n, v, res_word, res_carry, ew, ec);
    end
    checks++;
    if (carry_upd !== (n != 0)) begin
      errors++;
      $display("FAIL R9 n=%0d: carry_upd %0b, expected %0b", n, carry_upd, (n != 0));
    end
  endtask

  initial begin
    logic [31:0] pats [6];
    pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE; pats[2] = 32'hA5C3_0F96;
    pats[3] = 32'h0000_0000; pats[4] = 32'hFFFF_FFFF; pats[5] = 32'h1234_8765;
    data_in = '0; shift_amt = '0; shift_kind = '0; carry_in = 1'b0;
    @(negedge clk);
    // reset-like state: zero count passes through (R2)
    run_one(32'hDEAD_BEEF, 2'b00, 0, 24'h0, 1'b1, "R2");
    for (int p = 0; p < 6; p++)
      for (int k = 0; k < 4; k++)
        for (int n = 0; n < 256; n++)
          run_one(pats[p], 2'(k), n, 24'h0, 1'((p + n) & 1), req_tag(2'(k), n));
    // R1: upper amount bits must not affect outputs
    for (int k = 0; k < 4; k++)
      for (int n = 0; n < 256; n += 7)
        run_one(32'hC001_D00D, 2'(k), n, 24'hFFFFFF - 24'(n * 977), 1'(n & 1), "R1");
    // R8 boundary: rotate by 32 and 224 with carry_in opposite to bit 31
    run_one(32'h4000_0000, 2'b11, 32, 24'h0, 1'b1, "R8");
    run_one(32'h8000_0000, 2'b11, 224, 24'h0, 1'b0, "R8");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule